// File: doc/BRIEF.md
# TDM HDLC Transmit Channel Sequencer

This block is the transmit engine of one channel that owns a single 8-bit time slot in every TDM frame. On each slot strobe it presents exactly one byte. Frame payload is taken from a buffer in memory, read as 32-bit words, so one memory read feeds four successive slots. After the final payload byte the channel sends a 16-bit frame check sequence over two slots, then two flag slots. The buffer is closed during the first flag slot and the next one is opened during the second. When no descriptor is ready, the channel keeps sending flags and polls the descriptor once per slot.

Memory traffic goes through a single-beat port. A request is held until the memory returns a grant pulse. Every access a slot needs is launched by that slot's strobe. The counts are fixed: none in payload or check slots except for a word refill, three when closing, and three when opening a ready descriptor. A buffer descriptor is two words. Word 0 holds the status and length, and word 1 holds the data pointer. An interrupt-table entry is written for every closed buffer.

Top module: `tdm_txseq`

## Requirements
- R1: Each `slot_stb` pulse makes `tx_vld` high for exactly the one following cycle. `tx_byte` holds that slot's byte in that cycle.
- R2: Payload bytes go out in buffer order, the byte in bits 7:0 of each word first. A data word is read in the slot that sends the last byte of the previous word, but not after the final byte. Other payload slots make no memory access.
- R3: The two slots after the final payload byte carry the complemented CRC-16 (polynomial 0x1021 processed LSB first, i.e. reflected constant 0x8408, preset 0xFFFF, over the payload bytes), low byte first, and make no memory access.
- R4: The closing slot sends 0x7E and makes three accesses in this order: read `INT_ADDR`; write `INT_ADDR` with bit 31 set and the descriptor word address in the low bits; write descriptor word 0 with bit 31 cleared and all other bits unchanged.
- R5: An opening slot sends 0x7E and reads descriptor word 0. If its bit 31 (ready) is set, the slot then reads word 1 (data word address in the low bits) and the first data word at that address. The next slot sends the first payload byte. Bits 15:0 of word 0 give the length in bytes, at least 1.
- R6: If ready is clear, the opening slot makes only that single read, and every later slot sends 0x7E and re-reads the same descriptor.
- R7: After a close, the descriptor pointer returns to `BD_BASE` if bit 29 (wrap) of word 0 was set, and otherwise advances by two words.
- R8: `irq_evt` pulses for one cycle, the cycle after the grant of the interrupt-table write.
- R9: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_gnt`, and each grant completes one access.
- R10: A strobe that arrives while accesses are still pending sets `underrun`, which stays set until reset. That slot sends 0x7E, and the sequence is neither advanced nor given new accesses.
- R11: After reset, `tx_vld`, `mem_req`, `irq_evt` and `underrun` are low and the channel polls the descriptor at `BD_BASE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_stb | input | 1 | One-cycle pulse marking this channel's time slot |
| tx_byte | output | 8 | Byte for the current slot |
| tx_vld | output | 1 | Pulse qualifying `tx_byte` |
| mem_req | output | 1 | Memory access request, held until grant |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with the grant |
| mem_gnt | input | 1 | Grant pulse completing the access |
| irq_evt | output | 1 | Interrupt-table entry written |
| underrun | output | 1 | Sticky: a slot arrived before its accesses finished |

## Verification
Each result is due at a known cycle:
- The slot byte and `tx_vld` appear in the cycle after the strobe.
- A slot's first memory request rises in that same cycle.
- `irq_evt` follows the interrupt-write grant by one cycle.

The bench drives the strobe on a falling edge. It samples `tx_vld` and `tx_byte` at the very next falling edge. It counts grants and reads memory only near the end of a slot window, well after the last grant, and it checks access order from the log its memory model keeps.

// File: rtl/tdm_txseq_pkg.sv
package tdm_txseq_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned LANES   = WORD_W / BYTE_W;
    localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
    localparam int unsigned RDY_BIT  = 31;
    localparam int unsigned WRAP_BIT = 29;
    localparam int unsigned BD_WORDS = 2;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;

    typedef enum logic [2:0] {
        SL_OPEN,
        SL_DATA,
        SL_CRC_LO,
        SL_CRC_HI,
        SL_CLOSE
    } slot_e;

    typedef enum logic [1:0] {
        JOB_FETCH,
        JOB_CLOSE,
        JOB_OPEN
    } job_e;

    typedef struct packed {
        logic              vld;
        job_e              job;
        logic [1:0]        step;
        logic [WORD_W-1:0] data;
    } acc_evt_t;

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/tdm_txseq_crc.sv
module tdm_txseq_crc
    import tdm_txseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    logic [15:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || init) crc_q <= CRC_PRESET;
        else if (upd)    crc_q <= crc16_step(crc_q, din);
    end

    assign crc = crc_q;

    // R3: a new frame always begins from the preset value
    p_crc_preset_r3: assert property (@(posedge clk) disable iff (rst)
        init |=> (crc == CRC_PRESET));

endmodule

// File: rtl/tdm_txseq_wordbuf.sv
module tdm_txseq_wordbuf
    import tdm_txseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              adv,
    output logic [BYTE_W-1:0] byte_out,
    output logic              lane_last
);
    localparam int unsigned IW = $clog2(LANES);

    logic [LANES-1:0][BYTE_W-1:0] lane_q;
    logic [IW-1:0]                idx_q;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst)       lane_q[g] <= '0;
                else if (load) lane_q[g] <= word[g*BYTE_W +: BYTE_W];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || load) idx_q <= '0;
        else if (adv)    idx_q <= idx_q + IW'(1);
    end

    assign byte_out  = lane_q[idx_q];
    assign lane_last = (idx_q == IW'(LANES - 1));

endmodule

// File: rtl/tdm_txseq_mem.sv
module tdm_txseq_mem
    import tdm_txseq_pkg::*;
#(
    parameter int unsigned     AW       = 16,
    parameter logic [AW-1:0]   INT_ADDR = 'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  job_e              job_in,
    input  logic [AW-1:0]     bd_ptr,
    input  logic [AW-1:0]     buf_ptr,
    input  logic [WORD_W-1:0] bd_stat,
    output logic              busy,
    output acc_evt_t          evt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_gnt
);
    localparam int unsigned PADW = WORD_W - 1 - AW;

    logic       busy_q;
    job_e       job_q;
    logic [1:0] step_q;
    logic       fin;

    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = buf_ptr;
        mem_wdata = '0;
        fin       = 1'b1;
        unique case (job_q)
            JOB_CLOSE: begin
                fin = (step_q == 2'd2);
                unique case (step_q)
                    2'd0: mem_addr = INT_ADDR;
                    2'd1: begin
                        mem_addr  = INT_ADDR;
                        mem_we    = 1'b1;
                        mem_wdata = {1'b1, {PADW{1'b0}}, bd_ptr};
                    end
                    default: begin
                        mem_addr  = bd_ptr;
                        mem_we    = 1'b1;
                        mem_wdata = bd_stat & ~(WORD_W'(1) << RDY_BIT);
                    end
                endcase
            end
            JOB_OPEN: begin
                fin = (step_q == 2'd2) || ((step_q == 2'd0) && !mem_rdata[RDY_BIT]);
                unique case (step_q)
                    2'd0:    mem_addr = bd_ptr;
                    2'd1:    mem_addr = bd_ptr + AW'(1);
                    default: mem_addr = buf_ptr;
                endcase
            end
            default: begin
                mem_addr = buf_ptr;
                fin      = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            job_q  <= JOB_FETCH;
            step_q <= 2'd0;
        end else if (start) begin
            busy_q <= 1'b1;
            job_q  <= job_in;
            step_q <= 2'd0;
        end else if (busy_q && mem_gnt) begin
            if (fin) busy_q <= 1'b0;
            else     step_q <= step_q + 2'd1;
        end
    end

    assign busy     = busy_q;
    assign mem_req  = busy_q;
    assign evt.vld  = busy_q && mem_gnt;
    assign evt.job  = job_q;
    assign evt.step = step_q;
    assign evt.data = mem_rdata;

    // R9: a pending request keeps its address, direction and data
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

// File: rtl/tdm_txseq.sv
module tdm_txseq
    import tdm_txseq_pkg::*;
#(
    parameter int unsigned   AW       = 16,
    parameter int unsigned   LEN_W    = 16,
    parameter logic [AW-1:0] BD_BASE  = 'h100,
    parameter logic [AW-1:0] INT_ADDR = 'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_stb,
    output logic [7:0]        tx_byte,
    output logic              tx_vld,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_gnt,
    output logic              irq_evt,
    output logic              underrun
);
    slot_e             st_q;
    logic [LEN_W-1:0]  rem_q;
    logic [AW-1:0]     bd_ptr_q;
    logic [AW-1:0]     buf_ptr_q;
    logic [WORD_W-1:0] stat_q;

    logic              busy;
    acc_evt_t          evt;
    logic              go;
    logic              start;
    job_e              job;
    logic [7:0]        data_byte;
    logic              lane_last;
    logic [15:0]       crc;
    logic [7:0]        slot_byte;
    logic              wb_load;
    logic              frame_open;

    assign go         = slot_stb && !busy;
    assign frame_open = evt.vld && (evt.job == JOB_OPEN) && (evt.step == 2'd2);
    assign wb_load    = (evt.vld && (evt.job == JOB_FETCH)) || frame_open;

    always_comb begin
        slot_byte = FLAG_BYTE;
        start     = 1'b0;
        job       = JOB_OPEN;
        unique case (st_q)
            SL_DATA: begin
                slot_byte = data_byte;
                job       = JOB_FETCH;
                start     = go && lane_last && (rem_q != LEN_W'(1));
            end
            SL_CRC_LO: slot_byte = ~crc[7:0];
            SL_CRC_HI: slot_byte = ~crc[15:8];
            SL_CLOSE: begin
                job   = JOB_CLOSE;
                start = go;
            end
            default: begin
                job   = JOB_OPEN;
                start = go;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= SL_OPEN;
            rem_q     <= '0;
            bd_ptr_q  <= BD_BASE;
            buf_ptr_q <= '0;
            stat_q    <= '0;
            tx_byte   <= '0;
            tx_vld    <= 1'b0;
            irq_evt   <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            tx_vld  <= slot_stb;
            irq_evt <= evt.vld && (evt.job == JOB_CLOSE) && (evt.step == 2'd1);
            if (slot_stb) tx_byte <= busy ? FLAG_BYTE : slot_byte;
            if (slot_stb && busy) underrun <= 1'b1;

            if (go) begin
                unique case (st_q)
                    SL_DATA: begin
                        rem_q <= rem_q - LEN_W'(1);
                        if (rem_q == LEN_W'(1)) st_q <= SL_CRC_LO;
                    end
                    SL_CRC_LO: st_q <= SL_CRC_HI;
                    SL_CRC_HI: st_q <= SL_CLOSE;
                    SL_CLOSE:  st_q <= SL_OPEN;
                    default:   st_q <= SL_OPEN;
                endcase
            end

            if (evt.vld) begin
                unique case (evt.job)
                    JOB_FETCH: buf_ptr_q <= buf_ptr_q + AW'(1);
                    JOB_OPEN: begin
                        unique case (evt.step)
                            2'd0: begin
                                stat_q <= evt.data;
                                rem_q  <= evt.data[LEN_W-1:0];
                            end
                            2'd1: buf_ptr_q <= evt.data[AW-1:0];
                            default: begin
                                buf_ptr_q <= buf_ptr_q + AW'(1);
                                st_q      <= SL_DATA;
                            end
                        endcase
                    end
                    default: begin
                        if (evt.step == 2'd2)
                            bd_ptr_q <= stat_q[WRAP_BIT] ? BD_BASE : bd_ptr_q + AW'(BD_WORDS);
                    end
                endcase
            end
        end
    end

    tdm_txseq_mem #(.AW(AW), .INT_ADDR(INT_ADDR)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .job_in   (job),
        .bd_ptr   (bd_ptr_q),
        .buf_ptr  (buf_ptr_q),
        .bd_stat  (stat_q),
        .busy     (busy),
        .evt      (evt),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .mem_gnt  (mem_gnt)
    );

    tdm_txseq_wordbuf u_wbuf (
        .clk      (clk),
        .rst      (rst),
        .load     (wb_load),
        .word     (evt.data),
        .adv      (go && (st_q == SL_DATA)),
        .byte_out (data_byte),
        .lane_last(lane_last)
    );

    tdm_txseq_crc u_crc (
        .clk (clk),
        .rst (rst),
        .init(frame_open),
        .upd (go && (st_q == SL_DATA)),
        .din (data_byte),
        .crc (crc)
    );

    // R1: a byte qualifier only ever follows a slot strobe
    p_vld_follows_stb_r1: assert property (@(posedge clk) disable iff (rst)
        tx_vld |-> $past(slot_stb));

    // R5: a burst of accesses is only ever opened by a slot strobe
    p_req_from_stb_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(slot_stb));

    // R8: the interrupt event trails the interrupt-table write grant
    p_irq_after_write_r8: assert property (@(posedge clk) disable iff (rst)
        irq_evt |-> $past(mem_gnt && mem_we && (mem_addr == INT_ADDR)));

    // R10: underrun is sticky
    p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

endmodule

// File: tb/tdm_txseq_bench.sv
`timescale 1ns/1ps
module tdm_txseq_bench;
    localparam int AW   = 16;
    localparam int BDB  = 'h100;
    localparam int INTA = 'h80;
    localparam int GAP  = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slot_stb = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_vld;
    logic        mem_req;
    logic        mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_gnt = 1'b0;
    logic        irq_evt;
    logic        underrun;

    logic [31:0] mem [0:1023];
    int lat = 2, lat_cnt = 0, acc_cnt = 0, vld_cnt = 0, irq_cnt = 0, log_n = 0;
    int log_addr [0:4095];
    bit log_we   [0:4095];
    logic [7:0] last_byte = '0;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    tdm_txseq #(.AW(AW), .BD_BASE(16'h0100), .INT_ADDR(16'h0080)) u_tdm_txseq (
        .clk(clk), .rst(rst), .slot_stb(slot_stb), .tx_byte(tx_byte), .tx_vld(tx_vld),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .irq_evt(irq_evt), .underrun(underrun)
    );

    always @(negedge clk) begin
        if (mem_gnt) mem_gnt = 1'b0;
        else if (mem_req) begin
            if (lat_cnt >= lat) begin
                mem_rdata = mem[mem_addr[9:0]];
                if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
                if (log_n < 4096) begin
                    log_addr[log_n] = int'(mem_addr);
                    log_we[log_n]   = mem_we;
                    log_n++;
                end
                acc_cnt++;
                lat_cnt = 0;
                mem_gnt = 1'b1;
            end else lat_cnt++;
        end
        if (tx_vld) begin last_byte = tx_byte; vld_cnt++; end
        if (irq_evt) irq_cnt++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] != d[i]) r = (r >> 1) ^ 16'h8408;
            else              r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [7:0] fbyte(input int len, input int j);
        return 8'((len * 16 + j * 7 + 3) & 255);
    endfunction

    task automatic do_slot(output logic [7:0] b, output int acc, output int first_log);
        @(negedge clk);
        acc_cnt = 0; vld_cnt = 0; first_log = log_n;
        slot_stb = 1'b1;
        @(negedge clk);
        slot_stb = 1'b0;
        chk(tx_vld == 1'b1, "R1 vld after strobe", 32'(tx_vld), 32'd1);
        repeat (GAP - 2) @(negedge clk);
        chk(vld_cnt == 1, "R1 one byte per slot", 32'(vld_cnt), 32'd1);
        b = last_byte;
        acc = acc_cnt;
    endtask

    task automatic arm(input int len, input int bd, input bit wrap, input int dptr);
        for (int w = 0; w < (len + 3) / 4; w++) begin
            logic [31:0] wd = '0;
            for (int k = 0; k < 4; k++)
                if (4 * w + k < len) wd[8*k +: 8] = fbyte(len, 4 * w + k);
            mem[dptr + w] = wd;
        end
        mem[bd]     = {1'b1, 1'b0, wrap, 13'd0, 16'(len)};
        mem[bd + 1] = 32'(dptr);
    endtask

    // payload, check bytes and closing slot; opening slot handled by caller or play
    task automatic body(input int len, input int bd, input logic [31:0] stat);
        logic [7:0] b; int acc, fl, irq0;
        logic [15:0] c = 16'hFFFF;
        for (int j = 0; j < len; j++) begin
            do_slot(b, acc, fl);
            chk(b == fbyte(len, j), "R2 payload byte", 32'(b), 32'(fbyte(len, j)));
            chk(acc == (((j % 4) == 3 && j != len - 1) ? 1 : 0), "R2 word refill count",
                32'(acc), 32'(((j % 4) == 3 && j != len - 1) ? 1 : 0));
            c = crc_upd(c, fbyte(len, j));
        end
        c = ~c;
        do_slot(b, acc, fl);
        chk(b == c[7:0], "R3 crc low", 32'(b), 32'(c[7:0]));
        chk(acc == 0, "R3 no access", 32'(acc), 32'd0);
        do_slot(b, acc, fl);
        chk(b == c[15:8], "R3 crc high", 32'(b), 32'(c[15:8]));
        chk(acc == 0, "R3 no access", 32'(acc), 32'd0);
        irq0 = irq_cnt;
        do_slot(b, acc, fl);
        chk(b == 8'h7E, "R4 close flag", 32'(b), 32'h7E);
        chk(acc == 3, "R4 close accesses", 32'(acc), 32'd3);
        chk(log_addr[fl] == INTA && !log_we[fl], "R4 read int table", 32'(log_addr[fl]), 32'(INTA));
        chk(log_addr[fl+1] == INTA && log_we[fl+1], "R4 write int table", 32'(log_addr[fl+1]), 32'(INTA));
        chk(log_addr[fl+2] == bd && log_we[fl+2], "R4 write status", 32'(log_addr[fl+2]), 32'(bd));
        chk(mem[INTA] == {1'b1, 15'd0, 16'(bd)}, "R4 int entry", mem[INTA], {1'b1, 15'd0, 16'(bd)});
        chk(mem[bd] == (stat & 32'h7FFF_FFFF), "R4 ready cleared", mem[bd], stat & 32'h7FFF_FFFF);
        chk(irq_cnt == irq0 + 1, "R8 irq pulse", 32'(irq_cnt), 32'(irq0 + 1));
    endtask

    task automatic play(input int len, input int bd, input int dptr);
        logic [7:0] b; int acc, fl;
        logic [31:0] stat = mem[bd];
        do_slot(b, acc, fl);
        chk(b == 8'h7E, "R5 open flag", 32'(b), 32'h7E);
        chk(acc == 3, "R5 open accesses", 32'(acc), 32'd3);
        chk(log_addr[fl] == bd, "R5/R7 status read addr", 32'(log_addr[fl]), 32'(bd));
        chk(log_addr[fl+1] == bd + 1, "R5 pointer read addr", 32'(log_addr[fl+1]), 32'(bd + 1));
        chk(log_addr[fl+2] == dptr, "R5 first word addr", 32'(log_addr[fl+2]), 32'(dptr));
        body(len, bd, stat);
    endtask

    initial begin : main
        logic [7:0] b; int acc, fl;
        logic [31:0] stat;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        chk(tx_vld == 0 && mem_req == 0 && irq_evt == 0 && underrun == 0, "R11 reset outputs",
            {tx_vld, mem_req, irq_evt, underrun}, 32'd0);
        rst = 1'b0;

        // R6: no descriptor ready, poll the base descriptor
        for (int s = 0; s < 3; s++) begin
            do_slot(b, acc, fl);
            chk(b == 8'h7E, "R6 idle flag", 32'(b), 32'h7E);
            chk(acc == 1, "R6 single poll", 32'(acc), 32'd1);
            chk(log_addr[fl] == BDB && !log_we[fl], "R11 poll at base", 32'(log_addr[fl]), 32'(BDB));
        end

        // sweep over lengths across word boundaries, single wrapping descriptor
        for (int len = 1; len <= 9; len++) begin
            arm(len, BDB, 1'b1, 'h200);
            play(len, BDB, 'h200);
        end

        // R7: two-descriptor chain, the first without wrap
        arm(3, BDB, 1'b0, 'h240);
        arm(6, BDB + 2, 1'b1, 'h280);
        play(3, BDB, 'h240);
        play(6, BDB + 2, 'h280);
        do_slot(b, acc, fl);
        chk(acc == 1, "R6 cleared descriptor polled once", 32'(acc), 32'd1);
        chk(log_addr[fl] == BDB, "R7 wrap to base", 32'(log_addr[fl]), 32'(BDB));

        // R10: slow memory makes the open run past the next strobe
        arm(2, BDB, 1'b1, 'h2C0);
        stat = mem[BDB];
        lat = 20;
        do_slot(b, acc, fl);
        do_slot(b, acc, fl);
        chk(b == 8'h7E, "R10 flag on late slot", 32'(b), 32'h7E);
        chk(underrun == 1'b1, "R10 underrun set", 32'(underrun), 32'd1);
        repeat (80) @(negedge clk);
        lat = 2;
        body(2, BDB, stat);
        chk(underrun == 1'b1, "R10 underrun sticky", 32'(underrun), 32'd1);

        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(underrun == 0 && mem_req == 0 && tx_vld == 0, "R11 reset clears",
            {underrun, mem_req, tx_vld}, 32'd0);
        rst = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule